// File: doc/BRIEF.md
# Walking-Bit Data Line Tester

This block is a self-contained test engine that checks each data line of a 32-bit memory for bits that are stuck, open or shorted together. It acts as a master on a simple synchronous memory port. A one-cycle start pulse hands it a base address. The engine then writes 64 words. These are 32 walking-one values, and each one has its bitwise complement stored in the word just below it. After the last write it reads the same 64 words back. Every bit that differs from the value written is folded into a 32-bit error mask.

When the last read-back word has been folded in, the engine raises a one-cycle done pulse. The accumulated mask and a pass flag stay valid until the next run starts. A memory built from two interleaved word banks is covered by running the engine twice: once at an 8-byte-aligned base, and once at that base plus 4 bytes. Each bank then holds both polarities of every pattern. Read latency may vary, because the engine waits for the read-valid response before it compares a word.

Top module: `dlw_engine`

## Requirements
- R1: While reset is held and right after it, busy_o, done_o, mem_we_o and mem_re_o are low, err_mask_o is zero and pass_o is low.
- R2: After a start is accepted, the engine issues exactly 64 writes on consecutive cycles, starting the cycle after the start. Write k (k = 0..63) goes to base + 4*k with mem_be_o = 4'b1111. Its data is ~(1 << (k/2)) for even k and (1 << (k/2)) for odd k.
- R3: No read request is issued until all 64 writes are done. The reads then visit the same 64 addresses in the same ascending order, and a write and a read are never requested in the same cycle.
- R4: At most one read is outstanding. A read request lasts one cycle, and the next request comes only after mem_rvalid_i has returned the previous word. Any latency of one or more cycles is accepted.
- R5: The final err_mask_o is the bitwise OR, over all 64 read-back words, of (read data XOR value written). Both the complement word and the true word of every pair contribute.
- R6: done_o is a one-cycle pulse, raised the cycle after the last read data is accepted. pass_o is 1 exactly when the final mask is zero. The mask and pass_o hold their values until the next start is accepted.
- R7: busy_o is high from the cycle after an accepted start until done_o rises, and it is low while done_o is high. A start pulse seen while busy_o is high is ignored.
- R8: Bits [1:0] of base_i are ignored, so the base is always word aligned.
- R9: A rerun at a base 4 bytes above the previous one produces the same pattern sequence, shifted up by one word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a run |
| base_i | input | 32 | Byte base address of the test area |
| mem_addr_o | output | 32 | Byte address of the current access |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Byte enables for writes |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read request |
| mem_rdata_i | input | 32 | Read data |
| mem_rvalid_i | input | 1 | Read data valid |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_mask_o | output | 32 | Accumulated per-bit error mask |
| pass_o | output | 1 | Run found no faulty bit |

## Verification
A wrong word counter or a wrong polarity select shows up at the memory port in the very cycle it occurs. The bench catches it there, because it compares every write's address and data against a queue of expected transactions. A wrong phase state shows as a read mixed into the write phase, or as a second request before data returns, in the same cycle. An accumulator fault stays hidden until the done pulse. So the bench injects stuck bits into only one word bank at a time, which shows whether the even (complement) words and the odd (true) words are each folded into the final mask.

// File: rtl/dlw_pkg.sv
`timescale 1ns/1ps
package dlw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WRITE = 3'd1,
        ST_RREQ  = 3'd2,
        ST_RWAIT = 3'd3,
        ST_DONE  = 3'd4
    } dlw_state_e;
endpackage

// File: rtl/dlw_pattern.sv
`timescale 1ns/1ps
// Word k of a run: one-hot at bit k/2, inverted for even k.
module dlw_pattern #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] word
);
    localparam int PAIR_W = IDX_W - 1;

    logic [PAIR_W-1:0] pair;
    logic [DATA_W-1:0] one_hot;

    assign pair = idx[IDX_W-1:1];

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign one_hot[b] = (pair == PAIR_W'(b));
    end

    assign word = idx[0] ? one_hot : ~one_hot;
endmodule

// File: rtl/dlw_addr_gen.sv
`timescale 1ns/1ps
module dlw_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    assign addr = base + ADDR_W'({idx, 2'b00});
endmodule

// File: rtl/dlw_fold.sv
`timescale 1ns/1ps
module dlw_fold #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] mask_in,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] expect_word,
    output logic [DATA_W-1:0] mask_out
);
    assign mask_out = mask_in | (rdata ^ expect_word);
endmodule

// File: rtl/dlw_engine.sv
`timescale 1ns/1ps
module dlw_engine #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [DATA_W/8-1:0] mem_be_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_rvalid_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] err_mask_o,
    output logic              pass_o
);
    import dlw_pkg::*;

    localparam int BE_W  = DATA_W / 8;
    localparam int WORDS = 2 * DATA_W;
    localparam int IDX_W = $clog2(WORDS);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(WORDS - 1);
    localparam logic [ADDR_W-1:0] ALIGN_M  = ~ADDR_W'(3);

    typedef struct packed {
        dlw_state_e        st;
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] mask;
        logic              pass;
    } regs_t;

    regs_t r_d, r_q;

    logic [DATA_W-1:0] pat_word;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] folded;
    logic              idle_like;

    dlw_pattern #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_pattern (
        .idx  (r_q.idx),
        .word (pat_word)
    );

    dlw_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_addr_gen (
        .base (r_q.base),
        .idx  (r_q.idx),
        .addr (cur_addr)
    );

    dlw_fold #(.DATA_W(DATA_W)) i_fold (
        .mask_in     (r_q.mask),
        .rdata       (mem_rdata_i),
        .expect_word (pat_word),
        .mask_out    (folded)
    );

    assign idle_like = (r_q.st == ST_IDLE) || (r_q.st == ST_DONE);

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_WRITE: begin
                if (r_q.idx == LAST_IDX) begin
                    r_d.st  = ST_RREQ;
                    r_d.idx = '0;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_RREQ: r_d.st = ST_RWAIT;
            ST_RWAIT: begin
                if (mem_rvalid_i) begin
                    r_d.mask = folded;
                    if (r_q.idx == LAST_IDX) begin
                        r_d.st   = ST_DONE;
                        r_d.pass = (folded == '0);
                    end else begin
                        r_d.st  = ST_RREQ;
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (idle_like && start_i) begin
            r_d.st   = ST_WRITE;
            r_d.base = base_i & ALIGN_M;
            r_d.idx  = '0;
            r_d.mask = '0;
            r_d.pass = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign mem_we_o    = (r_q.st == ST_WRITE);
    assign mem_re_o    = (r_q.st == ST_RREQ);
    assign mem_addr_o  = cur_addr;
    assign mem_wdata_o = mem_we_o ? pat_word : '0;
    assign mem_be_o    = mem_we_o ? {BE_W{1'b1}} : '0;
    assign busy_o      = !idle_like;
    assign done_o      = (r_q.st == ST_DONE);
    assign err_mask_o  = r_q.mask;
    assign pass_o      = r_q.pass;
endmodule

// File: rtl/dlw_checker.sv
`timescale 1ns/1ps
module dlw_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W/8-1:0] mem_be_o,
    input logic              mem_we_o,
    input logic              mem_re_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [DATA_W-1:0] err_mask_o,
    input logic              pass_o
);
    p_rw_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o));

    p_full_be_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> mem_be_o == {(DATA_W/8){1'b1}});

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |-> mem_addr_o == $past(mem_addr_o) + ADDR_W'(4));

    p_one_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re_o |=> !mem_re_o);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    p_pass_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pass_o == (err_mask_o == '0)));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(err_mask_o) && $stable(pass_o)));
endmodule

bind dlw_engine dlw_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dlw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mem_addr_o (mem_addr_o),
    .mem_be_o   (mem_be_o),
    .mem_we_o   (mem_we_o),
    .mem_re_o   (mem_re_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_mask_o (err_mask_o),
    .pass_o     (pass_o)
);

// File: tb/test_dlw_engine.sv
`timescale 1ns/1ps
module test_dlw_engine;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] base_i = '0;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o;
    logic [3:0]    mem_be_o;
    logic          mem_we_o, mem_re_o;
    logic [DW-1:0] mem_rdata_i = '0;
    logic          mem_rvalid_i = 1'b0;
    logic          busy_o, done_o, pass_o;
    logic [DW-1:0] err_mask_o;

    int compared = 0;
    int mismatched = 0;

    always #2.5 clk = ~clk;

    dlw_engine #(.ADDR_W(AW), .DATA_W(DW)) i_dlw_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_be_o(mem_be_o),
        .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_rdata_i(mem_rdata_i),
        .mem_rvalid_i(mem_rvalid_i), .busy_o(busy_o), .done_o(done_o),
        .err_mask_o(err_mask_o), .pass_o(pass_o)
    );

    // ---------------- memory model with bank-wise stuck bits ----------------
    logic [DW-1:0] mem [logic [AW-1:0]];
    logic [DW-1:0] s0_even = '0, s1_even = '0, s0_odd = '0, s1_odd = '0;
    logic [AW-1:0] pend_addr = '0;
    int            pend_cnt = 0;
    int            lat_sel = 1;

    function automatic logic [DW-1:0] faulty(input logic [DW-1:0] w, input logic [AW-1:0] a);
        if (a[2]) return (w & ~s0_odd) | s1_odd;
        return (w & ~s0_even) | s1_even;
    endfunction

    always @(posedge clk) begin
        mem_rvalid_i <= 1'b0;
        if (mem_we_o) mem[mem_addr_o] = mem_wdata_o;
        if (mem_re_o) begin
            pend_addr = mem_addr_o;
            pend_cnt  = lat_sel;
            lat_sel   = (lat_sel == 3) ? 1 : lat_sel + 1;
        end else if (pend_cnt > 0) begin
            pend_cnt = pend_cnt - 1;
            if (pend_cnt == 0) begin
                mem_rvalid_i <= 1'b1;
                mem_rdata_i  <= faulty(mem.exists(pend_addr) ? mem[pend_addr] : '0, pend_addr);
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit            is_rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } item_t;
    item_t exp_q[$];

    function automatic logic [DW-1:0] pat(input int k);
        logic [DW-1:0] one;
        one = DW'(1) << (k / 2);
        return (k % 2 == 1) ? one : ~one;
    endfunction

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: every transaction at the port is popped and compared
    always @(negedge clk) begin
        if (rst_n && (mem_we_o || mem_re_o)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R3 unexpected access", mem_addr_o, '0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(it.is_rd == mem_re_o && it.is_rd != mem_we_o, "R3 access kind", {31'd0, mem_re_o}, {31'd0, it.is_rd});
                check(mem_addr_o == it.addr, "R2/R3 address", mem_addr_o, it.addr);
                if (!it.is_rd) begin
                    check(mem_wdata_o == it.data, "R2 write data", mem_wdata_o, it.data);
                    check(mem_be_o == 4'hF, "R2 byte enables", {28'd0, mem_be_o}, 32'hF);
                end
            end
        end
    end

    // driver: queues the expected run, starts it and checks the result
    task automatic run_test(input logic [AW-1:0] base, input int poke_at, input string tag);
        logic [AW-1:0] b_al;
        logic [DW-1:0] e_mask;
        logic [DW-1:0] hold_mask;
        int cyc;
        b_al = base & ~AW'(3);
        e_mask = '0;
        for (int k = 0; k < 64; k++) begin
            item_t it;
            it.is_rd = 1'b0; it.addr = b_al + AW'(4 * k); it.data = pat(k);
            exp_q.push_back(it);
            e_mask |= faulty(pat(k), it.addr) ^ pat(k);
        end
        for (int k = 0; k < 64; k++) begin
            item_t it;
            it.is_rd = 1'b1; it.addr = b_al + AW'(4 * k); it.data = '0;
            exp_q.push_back(it);
        end
        @(negedge clk);
        base_i  = base;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, {"R7 busy after start ", tag}, {31'd0, busy_o}, 32'd1);
        cyc = 0;
        while (!done_o && cyc < 2000) begin
            if (poke_at != 0 && cyc == poke_at) begin
                base_i = 32'h0000_9000; start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            cyc++;
            if (poke_at != 0 && cyc == poke_at + 1)
                check(busy_o == 1'b1, {"R7 start ignored while busy ", tag}, {31'd0, busy_o}, 32'd1);
        end
        start_i = 1'b0;
        if (!done_o) begin
            check(1'b0, {"watchdog run ", tag}, '0, 32'd1);
            exp_q.delete();
            return;
        end
        check(err_mask_o == e_mask, {"R5 final mask ", tag}, err_mask_o, e_mask);
        check(pass_o == (e_mask == '0), {"R6 pass flag ", tag}, {31'd0, pass_o}, {31'd0, e_mask == '0});
        check(busy_o == 1'b0, {"R7 busy low at done ", tag}, {31'd0, busy_o}, 32'd0);
        check(exp_q.size() == 0, {"R3 all reads seen ", tag}, exp_q.size(), 32'd0);
        hold_mask = err_mask_o;
        @(negedge clk);
        check(done_o == 1'b0, {"R6 done one cycle ", tag}, {31'd0, done_o}, 32'd0);
        repeat (3) @(negedge clk);
        check(err_mask_o == hold_mask, {"R6 mask held ", tag}, err_mask_o, hold_mask);
    endtask

    initial begin
        #(5.0 * 150000);
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared + 1, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy_o == 0 && done_o == 0, "R1 busy/done in reset", {30'd0, busy_o, done_o}, 32'd0);
        check(mem_we_o == 0 && mem_re_o == 0, "R1 no access in reset", {30'd0, mem_we_o, mem_re_o}, 32'd0);
        check(err_mask_o == '0 && pass_o == 0, "R1 mask/pass in reset", err_mask_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 0 && mem_we_o == 0, "R1 idle after reset", {30'd0, busy_o, mem_we_o}, 32'd0);

        // R2 R3 R4 R6: clean memory, varying read latency
        run_test(32'h0000_1000, 0, "clean");
        // R9: rerun one word higher
        run_test(32'h0000_1004, 0, "rerun+4");
        // R8: unaligned base bits ignored
        run_test(32'h0000_2003, 0, "unaligned");
        // R5: stuck bits in both banks
        s0_even = 32'h0000_0100; s0_odd = 32'h0000_0100;
        s1_even = 32'h8000_0000; s1_odd = 32'h8000_0000;
        run_test(32'h0000_3000, 0, "stuck both");
        // R5: complement words alone carry the fault
        s0_even = 32'h0000_0020; s1_even = '0; s0_odd = '0; s1_odd = '0;
        run_test(32'h0000_4000, 0, "even bank");
        // R5: true words alone carry the fault
        s0_even = '0; s1_odd = 32'h0000_1000;
        run_test(32'h0000_5000, 0, "odd bank");
        // R9 with fault in the odd bank: banks swap roles at base+4
        run_test(32'h0000_5004, 0, "odd bank +4");
        // R7: start pulse during the write phase is ignored
        s1_odd = '0;
        run_test(32'h0000_6000, 10, "poke write");
        // R7: start pulse during the read phase is ignored
        run_test(32'h0000_7000, 100, "poke read");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule